// File: doc/BRIEF.md
# Flash Line Prefetch Buffer Controller

This block sits between a 32-bit system bus read port and a flash array whose read port returns a whole 128-bit page. It holds four page-wide line buffers. Each buffer keeps a page tag, a valid flag and four 32-bit words. A request whose page is held in a valid buffer is answered in the cycle it arrives. A request that misses starts one array read. The returned page is registered into a buffer, and the bus is then served from that buffer, so every miss costs a fixed two wait states.

After a demand fill of page N, the controller can fetch page N+1 into another buffer while the array is otherwise idle. A two-bit mode input decides which demand fills may trigger this prefetch: bit 0 enables it after instruction fetches, and bit 1 enables it after data reads. Buffers are replaced in least-recently-used order. A single-cycle invalidate input empties every buffer after the array contents have changed.

The sequencer has three states:
- `ST_IDLE`: the array is idle.
- `ST_DEMAND`: a demand page is returning.
- `ST_PREFETCH`: a speculative page is returning.

The transitions are as follows:
- `ST_IDLE` moves to `ST_DEMAND` when a request misses.
- `ST_IDLE` moves to `ST_PREFETCH` when a prefetch is pending and its page is not already buffered.
- `ST_DEMAND` and `ST_PREFETCH` both return to `ST_IDLE` on the next cycle, writing the page into its buffer.
- The invalidate input forces `ST_IDLE` from any state and discards any fill in flight.

Top module: `flash_line_prefetch`

## Requirements
- R1: A word-aligned request (`req_addr[1:0]` = 0) whose page is held in a valid buffer gets `req_ready` high in the same cycle. `req_rdata` is then the word selected by `req_addr[3:2]`, with word k taken from line bits [32k+31:32k]. Hits are also served while a fill is in progress.
- R2: A request that misses raises `arr_en` in its arrival cycle, with `arr_addr` equal to the request address with bits [3:0] cleared. The page on `arr_line` one cycle later is captured, and `req_ready` rises two cycles after arrival (two wait states). Exactly one array read is made per miss.
- R3: After a demand fill of page N, exactly one read of address N+16 is issued in the following cycle when the access is enabled for prefetch. `pf_mode` bit 0 enables this after instruction fetches (`req_instr`=1), and bit 1 enables it after data reads. When the access is not enabled, no prefetch read is made.
- R4: A prefetch is skipped when page N+1 is already in a valid buffer. No page is ever held in two valid buffers.
- R5: A request for the page that a prefetch is currently fetching starts no array read of its own. It is served in the cycle after that fill, which is one wait state when it arrives in the fill cycle.
- R6: On a miss, the buffer least recently allocated or hit is replaced. The buffer hit in the same cycle is never chosen as the victim.
- R7: While `inv` is high, every valid flag is cleared on the next edge and a fill in progress is discarded. A held request then misses again; with `inv` in the fill cycle it completes after four wait states.
- R8: After reset no buffer is valid, `req_ready` and `arr_en` are low, and the first request misses.
- R9: A miss that arrives while the array is busy waits for the array to become idle before its own read starts. Array reads are never issued in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_mode | input | 2 | Prefetch enable: bit 0 after instruction fills, bit 1 after data fills |
| inv | input | 1 | Invalidate all buffers |
| req_valid | input | 1 | Bus read request, held until accepted |
| req_addr | input | 32 | Bus byte address, word aligned |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_ready | output | 1 | Request accepted; read data valid this cycle |
| req_rdata | output | 32 | Read data |
| arr_en | output | 1 | Array page read strobe |
| arr_addr | output | 32 | Page-aligned array read address |
| arr_line | input | 128 | Page returned by the array one cycle after `arr_en` |

## Verification
The bench runs a long pattern of reads over six pages with prefetch off. A recency list of four pages predicts hit or miss for each read, so a victim chosen by age of fill rather than last use, or a victim equal to a just-hit buffer, shows up as a wrong wait count. Every combination of prefetch mode and access attribute is swept. This catches a design that swaps the two mode bits or prefetches on every fill, because the next-page read then costs the wrong number of waits. Back-to-back reads into a prefetch in flight, and a foreign miss during it, catch a design that starts a second array read or drops the fill; the read counter and the one-wait or three-wait response expose both. An invalidate pulse placed in the fill cycle catches a design that still writes the stale page, because that design would answer after two waits instead of four.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEMAND   = 2'd1,
        ST_PREFETCH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pfb_lines.sv
module pfb_lines #(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 28,
    parameter int LINE_W    = 128,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [IDX_W-1:0]  look_idx,
    output logic [LINE_W-1:0] look_line,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              probe_hit,
    input  logic              drop_en,
    input  logic [IDX_W-1:0]  drop_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];
    logic [NUM_LINES-1:0] match_a;
    logic [NUM_LINES-1:0] match_b;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        assign match_a[i] = valid_q[i] && (tag_q[i] == look_tag);
        assign match_b[i] = valid_q[i] && (tag_q[i] == probe_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (inv) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == MY_IDX) begin
                valid_q[i] <= 1'b1;
            end else if (drop_en && drop_idx == MY_IDX) begin
                valid_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == MY_IDX) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_line;
            end
        end
    end

    assign look_hit  = |match_a;
    assign probe_hit = |match_b;

    always_comb begin
        look_idx  = '0;
        look_line = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (match_a[i]) begin
                look_idx  = look_idx | IDX_W'(i);
                look_line = look_line | data_q[i];
            end
        end
    end

    // Duplicate detection for the checks below.
    logic dup_tag;
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            for (int j = i + 1; j < NUM_LINES; j++) begin
                if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup_tag = 1'b1;
            end
        end
    end

    // R4: a page never sits in two valid buffers
    a_r4_unique_tags: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);
    // R7: invalidate empties every buffer on the next edge
    a_r7_inv_empties: assert property (@(posedge clk) disable iff (!rst_n) inv |=> (valid_q == '0));
endmodule

// File: rtl/pfb_lru.sv
module pfb_lru #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_LINES - 1);

    logic [IDX_W-1:0]     age_q   [NUM_LINES];
    logic [IDX_W-1:0]     age_mid [NUM_LINES];
    logic [IDX_W-1:0]     age_d   [NUM_LINES];
    logic [IDX_W-1:0]     target;
    logic [NUM_LINES-1:0] oldest_vec;

    // Allocation is applied first, then the hit, so a hit ends youngest.
    always_comb begin
        for (int j = 0; j < NUM_LINES; j++) begin
            age_mid[j] = age_q[j];
            if (alloc_en) begin
                if (IDX_W'(j) == alloc_idx)            age_mid[j] = '0;
                else if (age_q[j] < age_q[alloc_idx])  age_mid[j] = age_q[j] + 1'b1;
            end
        end
        for (int j = 0; j < NUM_LINES; j++) begin
            age_d[j] = age_mid[j];
            if (hit_en) begin
                if (IDX_W'(j) == hit_idx)                  age_d[j] = '0;
                else if (age_mid[j] < age_mid[hit_idx])    age_d[j] = age_mid[j] + 1'b1;
            end
        end
    end

    always_comb begin
        target = (hit_en && age_q[hit_idx] == OLDEST) ? OLDEST - 1'b1 : OLDEST;
        victim = '0;
        for (int j = 0; j < NUM_LINES; j++) begin
            oldest_vec[j] = (age_q[j] == OLDEST);
            if (age_q[j] == target) victim = IDX_W'(j);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_LINES; j++) age_q[j] <= IDX_W'(j);
        end else begin
            for (int j = 0; j < NUM_LINES; j++) age_q[j] <= age_d[j];
        end
    end

    // R6: the ages always form a ranking with a single oldest buffer
    a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest_vec));
    // R6: the buffer hit this cycle is never the replacement choice
    a_r6_victim_not_hit: assert property (@(posedge clk) disable iff (!rst_n) hit_en |-> (victim != hit_idx));
endmodule

// File: rtl/pfb_seq.sv
module pfb_seq
    import pfb_pkg::*;
#(
    parameter int TAG_W = 28,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic [1:0]       pf_mode,
    input  logic             req_valid,
    input  logic             req_instr,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_hit,
    input  logic             pf_present,
    input  logic [IDX_W-1:0] victim,
    output logic             arr_en,
    output logic [TAG_W-1:0] arr_tag,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output logic [TAG_W-1:0] pf_tag
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] fill_idx_q;
    logic [TAG_W-1:0] fill_tag_q;
    logic             fill_instr_q;
    logic             pf_pend_q;
    logic [TAG_W-1:0] pf_tag_q;
    logic             issue_demand;
    logic             issue_pf;
    logic             pf_allowed;

    assign pf_allowed = fill_instr_q ? pf_mode[0] : pf_mode[1];

    // Next state and outputs.
    always_comb begin
        state_d      = state_q;
        issue_demand = 1'b0;
        issue_pf     = 1'b0;
        wr_en        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!inv) begin
                    if (req_valid && !req_hit) begin
                        issue_demand = 1'b1;
                        state_d      = ST_DEMAND;
                    end else if (pf_pend_q && !pf_present) begin
                        issue_pf = 1'b1;
                        state_d  = ST_PREFETCH;
                    end
                end
            end
            ST_DEMAND, ST_PREFETCH: begin
                wr_en   = !inv;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (inv) state_d = ST_IDLE;
        arr_en  = issue_demand | issue_pf;
        arr_tag = issue_demand ? req_tag : pf_tag_q;
    end

    assign wr_idx = fill_idx_q;
    assign wr_tag = fill_tag_q;
    assign pf_tag = pf_tag_q;

    // State register and fill bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            fill_idx_q   <= '0;
            fill_tag_q   <= '0;
            fill_instr_q <= 1'b0;
            pf_pend_q    <= 1'b0;
            pf_tag_q     <= '0;
        end else begin
            state_q <= state_d;
            if (arr_en) begin
                fill_idx_q   <= victim;
                fill_tag_q   <= arr_tag;
                fill_instr_q <= req_instr;
            end
            if (inv) begin
                pf_pend_q <= 1'b0;
            end else if (state_q == ST_DEMAND) begin
                pf_pend_q <= pf_allowed;
                pf_tag_q  <= fill_tag_q + TAG_W'(1);
            end else if (state_q == ST_IDLE) begin
                pf_pend_q <= 1'b0;
            end
        end
    end

    // R9: the array never sees reads in consecutive cycles
    a_r9_reads_spaced: assert property (@(posedge clk) disable iff (!rst_n) arr_en |=> !arr_en);
    // R2: every read is written into a buffer next cycle unless invalidated
    a_r2_fill_next_cycle: assert property (@(posedge clk) disable iff (!rst_n) arr_en |=> (wr_en || inv));
    // R3: a prefetch read only ever follows a demand fill
    a_r3_pf_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
        issue_pf |-> ($past(state_q) == ST_DEMAND));
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch #(
    parameter int AW         = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   pf_mode,
    input  logic                         inv,
    input  logic                         req_valid,
    input  logic [AW-1:0]                req_addr,
    input  logic                         req_instr,
    output logic                         req_ready,
    output logic [WORD_W-1:0]            req_rdata,
    output logic                         arr_en,
    output logic [AW-1:0]                arr_addr,
    input  logic [WORD_W*LINE_WORDS-1:0] arr_line
);
    localparam int LINE_W  = WORD_W * LINE_WORDS;
    localparam int BYTE_SH = $clog2(WORD_W / 8);
    localparam int SEL_W   = $clog2(LINE_WORDS);
    localparam int OFF_W   = BYTE_SH + SEL_W;
    localparam int TAG_W   = AW - OFF_W;
    localparam int IDX_W   = $clog2(NUM_LINES);

    logic [TAG_W-1:0]  req_tag;
    logic [SEL_W-1:0]  word_sel;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [LINE_W-1:0] hit_line;
    logic [TAG_W-1:0]  pf_tag;
    logic              pf_present;
    logic [IDX_W-1:0]  victim;
    logic [TAG_W-1:0]  arr_tag;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;

    assign req_tag   = req_addr[AW-1:OFF_W];
    assign word_sel  = req_addr[BYTE_SH +: SEL_W];
    assign req_ready = req_valid && hit;
    assign req_rdata = hit_line[word_sel*WORD_W +: WORD_W];
    assign arr_addr  = {arr_tag, {OFF_W{1'b0}}};

    pfb_lines #(
        .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .inv(inv),
        .look_tag(req_tag), .look_hit(hit), .look_idx(hit_idx), .look_line(hit_line),
        .probe_tag(pf_tag), .probe_hit(pf_present),
        .drop_en(arr_en), .drop_idx(victim),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(arr_line)
    );

    pfb_lru #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(arr_en), .alloc_idx(victim),
        .hit_en(req_ready), .hit_idx(hit_idx),
        .victim(victim)
    );

    pfb_seq #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .inv(inv), .pf_mode(pf_mode),
        .req_valid(req_valid), .req_instr(req_instr), .req_tag(req_tag),
        .req_hit(hit), .pf_present(pf_present), .victim(victim),
        .arr_en(arr_en), .arr_tag(arr_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .pf_tag(pf_tag)
    );

    // R1: requests are whole aligned words
    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[BYTE_SH-1:0] == '0));
endmodule

// File: tb/flash_line_prefetch_bench.sv
module flash_line_prefetch_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   pf_mode = 2'b00;
    logic         inv = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_instr = 1'b0;
    logic         req_ready;
    logic [31:0]  req_rdata;
    logic         arr_en;
    logic [31:0]  arr_addr;
    logic [127:0] arr_line = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_count = 0;
    logic [31:0] last_rd = '0;

    always #10 clk = ~clk;

    flash_line_prefetch u_flash_line_prefetch (
        .clk(clk), .rst_n(rst_n), .pf_mode(pf_mode), .inv(inv),
        .req_valid(req_valid), .req_addr(req_addr), .req_instr(req_instr),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .arr_en(arr_en), .arr_addr(arr_addr), .arr_line(arr_line)
    );

    function automatic logic [31:0] wexp(input logic [31:0] a);
        return (a ^ 32'hC0DE_0000) + {a[15:0], a[31:16]};
    endfunction

    // Array model: page appears one cycle after the strobe.
    always @(posedge clk) begin
        if (arr_en) begin
            for (int k = 0; k < 4; k++) arr_line[k*32 +: 32] <= wexp(arr_addr + 32'(k * 4));
            rd_count <= rd_count + 1;
            last_rd  <= arr_addr;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input bit ins, input int inv_at,
                      output int waits, output logic [31:0] data);
        req_valid = 1'b1;
        req_addr  = a;
        req_instr = ins;
        waits = 0;
        data  = '0;
        for (int guard = 0; guard < 40; guard++) begin
            inv = (waits == inv_at);
            #1;
            if (req_ready) begin
                data = req_rdata;
                break;
            end
            waits++;
            @(negedge clk);
        end
        inv = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_chk(input logic [31:0] a, input bit ins, input int exp_w, input string req);
        int w;
        logic [31:0] d;
        rd(a, ins, -1, w, d);
        check(w == exp_w, req, "wait states", 32'(w), 32'(exp_w));
        check(d == wexp(a), req, "read data", d, wexp(a));
    endtask

    task automatic do_inv();
        inv = 1'b1;
        @(negedge clk);
        inv = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0;
        logic [31:0] q[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle outputs after reset
        check(req_ready == 1'b0, "R8", "ready after reset", 32'(req_ready), 0);
        check(arr_en == 1'b0, "R8", "arr_en after reset", 32'(arr_en), 0);
        // R8 / R2: first read misses, page-aligned array address
        read_chk(32'h0000_200C, 1'b0, 2, "R8");
        check(last_rd == 32'h0000_2000, "R2", "array address", last_rd, 32'h0000_2000);
        check(rd_count == 1, "R2", "read count", 32'(rd_count), 1);
        // R1: remaining words of the page hit with no wait
        for (int k = 0; k < 3; k++) read_chk(32'h0000_2000 + 32'(k * 4), 1'b0, 0, "R1");
        check(rd_count == 1, "R1", "no read on hits", 32'(rd_count), 1);

        // R6: replacement sweep against a recency list, prefetch off
        do_inv();
        q = {};
        c0 = rd_count;
        for (int i = 0; i < 240; i++) begin
            int p;
            int pos;
            logic [31:0] pg;
            p  = (i * i + 3 * i + i / 7) % 6;
            pg = 32'h0000_4000 + 32'(p * 16);
            pos = -1;
            for (int j = 0; j < q.size(); j++) if (q[j] == pg) pos = j;
            read_chk(pg + 32'((i * 3) % 4 * 4), i[0], (pos >= 0) ? 0 : 2, "R6");
            if (pos >= 0) q.delete(pos);
            else begin
                if (q.size() == 4) void'(q.pop_back());
                c0++;
            end
            q.push_front(pg);
            if (i % 5 == 0) @(negedge clk);
        end
        check(rd_count == c0, "R2", "one read per miss", 32'(rd_count), 32'(c0));

        // R3: every prefetch mode against both attributes
        for (int m = 0; m < 4; m++) begin
            for (int ins = 0; ins < 2; ins++) begin
                logic [31:0] b;
                bit en;
                b  = 32'h0000_8000 + 32'((m * 2 + ins) * 256);
                en = (ins == 1) ? m[0] : m[1];
                do_inv();
                pf_mode = 2'(m);
                c0 = rd_count;
                read_chk(b, ins[0], 2, "R3");
                repeat (4) @(negedge clk);
                check(rd_count - c0 == (en ? 2 : 1), "R3", "reads after fill", 32'(rd_count - c0), en ? 2 : 1);
                if (en) check(last_rd == b + 16, "R3", "prefetch address", last_rd, b + 16);
                read_chk(b + 16, ins[0], en ? 0 : 2, "R3");
            end
        end

        // R4: prefetch skipped when next page is already present
        do_inv();
        pf_mode = 2'b11;
        c0 = rd_count;
        read_chk(32'h0001_0010, 1'b1, 2, "R4");
        repeat (4) @(negedge clk);
        read_chk(32'h0001_0000, 1'b1, 2, "R4");
        repeat (4) @(negedge clk);
        check(rd_count - c0 == 3, "R4", "read count", 32'(rd_count - c0), 3);
        read_chk(32'h0001_0014, 1'b1, 0, "R4");
        read_chk(32'h0001_0020, 1'b1, 0, "R4");

        // R5: request joins prefetch in flight
        do_inv();
        c0 = rd_count;
        read_chk(32'h0002_0000, 1'b0, 2, "R5");
        read_chk(32'h0002_0018, 1'b0, 1, "R5");
        check(rd_count - c0 == 2, "R5", "no second read", 32'(rd_count - c0), 2);

        // R9: foreign miss while prefetch in flight; hit during later prefetch
        do_inv();
        c0 = rd_count;
        read_chk(32'h0003_0000, 1'b1, 2, "R9");
        read_chk(32'h0005_0004, 1'b1, 3, "R9");
        read_chk(32'h0003_0010, 1'b1, 0, "R1");
        repeat (3) @(negedge clk);
        check(rd_count - c0 == 4, "R9", "read count", 32'(rd_count - c0), 4);

        // R7: invalidate during a fill, then full clear
        pf_mode = 2'b00;
        do_inv();
        read_chk(32'h0006_0000, 1'b0, 2, "R7");
        c0 = rd_count;
        begin
            int w;
            logic [31:0] d;
            rd(32'h0007_0008, 1'b0, 1, w, d);
            check(w == 4, "R7", "wait states with discard", 32'(w), 4);
            check(d == wexp(32'h0007_0008), "R7", "data after discard", d, wexp(32'h0007_0008));
        end
        check(rd_count - c0 == 2, "R7", "re-read count", 32'(rd_count - c0), 2);
        do_inv();
        read_chk(32'h0006_0004, 1'b0, 2, "R7");
        read_chk(32'h0007_0000, 1'b0, 2, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule